// File: doc/BRIEF.md
# Cause-Classified Data Bus Arbiter

This block decides which internal agent owns a shared processor/memory data bus. Five kinds of agent compete: a copy-back buffer flush engine, a PCI write-buffer flush engine, a PCI read path, a parameterised group of processor/L2 transfer ports, and a speculative read-buffer prefetcher. Each agent drives a request line together with flags that state why it is asking. From those flags the block places each agent, every cycle, at one of ten priority levels, where 1 is the most urgent and 10 the least.

The flush engines and the PCI read path move between levels as their flags change. The copy-back flush sits at 1, 5 or 8. The write-buffer flush sits at 4 or 9. The PCI read sits at 2 or 7, depending on whether its snoop has finished. A transfer port sits at 3 or 6, depending on its priority tag. The prefetcher is always at 10. Whenever the bus is free, the block picks the lowest-numbered level. Among transfer ports on the same level, the lowest port index wins.

The winner gets a registered one-hot grant. It keeps that grant, and cannot be preempted, until it pulses `done_i`. Arbitration happens at the same clock edge that samples `done_i`, so the next owner's grant is visible in the cycle after the done pulse.

Top module: `dbus_cause_arb`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `grant_o` is all zero.
- R2: When the bus is free and no request line is high, `grant_o` is all zero in the next cycle.
- R3: At most one bit of `grant_o` is ever set. The bit positions are: 0 copy-back flush, 1 write-buffer flush, 2 PCI read, 3 prefetch, and 4+k for transfer port k.
- R4: Once a grant is issued, it stays unchanged until a cycle in which `done_i` is high, whatever the request and cause inputs do.
- R5: A copy-back flush with any bit of `cbf_hi_cause_i` set is at level 1 and beats every other request.
- R6: A copy-back flush with no high cause is at level 5 if any bit of `cbf_med_cause_i` is set, and at level 8 otherwise.
- R7: A write-buffer flush is at level 4 if any bit of `wbf_hi_cause_i` is set, and at level 9 otherwise.
- R8: A PCI read is at level 2 when `prd_snoop_done_i` is 1, and at level 7 when it is 0.
- R9: A transfer port is at level 3 when its `xfer_prio_i` bit is 1, and at level 6 when it is 0. Among equal-level ports, the lowest index wins.
- R10: A prefetch request is at level 10. It is granted only when no other request is present.
- R11: If at least one request is present when the bus is free (grant all zero, or `done_i` high), a grant is registered at that edge. The grant is visible in the following cycle.
- R12: An agent whose flags select several levels at once competes at the most urgent of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cbf_req_i | input | 1 | Copy-back buffer flush request |
| cbf_hi_cause_i | input | CBF_HI_N (5) | Urgent flush causes (level 1) |
| cbf_med_cause_i | input | CBF_MED_N (3) | Medium flush causes (level 5) |
| wbf_req_i | input | 1 | PCI write-buffer flush request |
| wbf_hi_cause_i | input | WBF_HI_N (4) | Urgent write-buffer flush causes (level 4) |
| prd_req_i | input | 1 | PCI read from memory request |
| prd_snoop_done_i | input | 1 | Snoop for the PCI read has finished |
| xfer_req_i | input | NXFER (4) | Processor/L2 transfer requests |
| xfer_prio_i | input | NXFER (4) | Per-port priority tag |
| pf_req_i | input | 1 | Speculative read-buffer prefetch request |
| done_i | input | 1 | Current owner has finished its transfer |
| grant_o | output | NXFER+4 (8) | Registered one-hot grant |

## Verification
The main sweep runs every combination of per-agent request classes: each agent is off or at each of its possible levels, with two transfer ports. The cause bit that selects a level rotates across the flag vectors, so every bit of each cause vector is seen to promote its agent. Each combination tells apart two adjacent levels that a wrong mapping would swap, such as 2 against 3, 4 against 5, 7 against 8 and 9 against 10. Equal-level transfer ports expose a reversed tie order. Directed sequences change requests while a grant is held, hand the bus over in the cycle of a done pulse, and raise high and medium flags together.

// File: rtl/dbus_arb_pkg.sv
package dbus_arb_pkg;

    typedef logic [3:0] lvl_t;

    localparam lvl_t LVL_NONE      = 4'd15;
    localparam lvl_t LVL_CBF_HI    = 4'd1;
    localparam lvl_t LVL_PRD_DONE  = 4'd2;
    localparam lvl_t LVL_XFER_PRIO = 4'd3;
    localparam lvl_t LVL_WBF_HI    = 4'd4;
    localparam lvl_t LVL_CBF_MED   = 4'd5;
    localparam lvl_t LVL_XFER_NORM = 4'd6;
    localparam lvl_t LVL_PRD_WAIT  = 4'd7;
    localparam lvl_t LVL_CBF_LOW   = 4'd8;
    localparam lvl_t LVL_WBF_LOW   = 4'd9;
    localparam lvl_t LVL_PREFETCH  = 4'd10;

    localparam int SRC_CBF   = 0;
    localparam int SRC_WBF   = 1;
    localparam int SRC_PRD   = 2;
    localparam int SRC_PF    = 3;
    localparam int SRC_XFER0 = 4;

endpackage

// File: rtl/dbus_arb_level_map.sv
module dbus_arb_level_map
    import dbus_arb_pkg::*;
#(
    parameter int CBF_HI_N  = 5,
    parameter int CBF_MED_N = 3,
    parameter int WBF_HI_N  = 4,
    parameter int NXFER     = 4,
    parameter int NSRC      = NXFER + 4
) (
    input  logic                      cbf_req_i,
    input  logic [CBF_HI_N-1:0]       cbf_hi_cause_i,
    input  logic [CBF_MED_N-1:0]      cbf_med_cause_i,
    input  logic                      wbf_req_i,
    input  logic [WBF_HI_N-1:0]       wbf_hi_cause_i,
    input  logic                      prd_req_i,
    input  logic                      prd_snoop_done_i,
    input  logic [NXFER-1:0]          xfer_req_i,
    input  logic [NXFER-1:0]          xfer_prio_i,
    input  logic                      pf_req_i,
    output logic [NSRC-1:0][3:0]      lvl_o
);

    logic [NXFER-1:0][3:0] xfer_lvl;

    // Transfer ports: one identical level decoder per port.
    for (genvar k = 0; k < NXFER; k++) begin : g_xfer
        always_comb begin
            if (!xfer_req_i[k]) begin
                xfer_lvl[k] = LVL_NONE;
            end else if (xfer_prio_i[k]) begin
                xfer_lvl[k] = LVL_XFER_PRIO;
            end else begin
                xfer_lvl[k] = LVL_XFER_NORM;
            end
        end
    end

    always_comb begin
        lvl_o = {NSRC{LVL_NONE}};

        // Copy-back flush: urgent flags dominate medium flags (most urgent wins).
        if (cbf_req_i) begin
            if (|cbf_hi_cause_i) begin
                lvl_o[SRC_CBF] = LVL_CBF_HI;
            end else if (|cbf_med_cause_i) begin
                lvl_o[SRC_CBF] = LVL_CBF_MED;
            end else begin
                lvl_o[SRC_CBF] = LVL_CBF_LOW;
            end
        end

        if (wbf_req_i) begin
            lvl_o[SRC_WBF] = (|wbf_hi_cause_i) ? LVL_WBF_HI : LVL_WBF_LOW;
        end

        if (prd_req_i) begin
            lvl_o[SRC_PRD] = prd_snoop_done_i ? LVL_PRD_DONE : LVL_PRD_WAIT;
        end

        if (pf_req_i) begin
            lvl_o[SRC_PF] = LVL_PREFETCH;
        end

        for (int k = 0; k < NXFER; k++) begin
            lvl_o[SRC_XFER0 + k] = xfer_lvl[k];
        end
    end

endmodule

// File: rtl/dbus_arb_pick.sv
module dbus_arb_pick
    import dbus_arb_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0][3:0] lvl_i,
    output logic [NSRC-1:0]      win_o
);

    lvl_t             best_lvl;
    logic [IDX_W-1:0] best_idx;

    // Strict less-than keeps the earliest index on equal levels.
    always_comb begin
        best_lvl = LVL_NONE;
        best_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (lvl_i[i] < best_lvl) begin
                best_lvl = lvl_i[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        win_o = '0;
        if (best_lvl != LVL_NONE) begin
            win_o[best_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/dbus_cause_arb.sv
module dbus_cause_arb
    import dbus_arb_pkg::*;
#(
    parameter int CBF_HI_N  = 5,
    parameter int CBF_MED_N = 3,
    parameter int WBF_HI_N  = 4,
    parameter int NXFER     = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cbf_req_i,
    input  logic [CBF_HI_N-1:0]  cbf_hi_cause_i,
    input  logic [CBF_MED_N-1:0] cbf_med_cause_i,
    input  logic                 wbf_req_i,
    input  logic [WBF_HI_N-1:0]  wbf_hi_cause_i,
    input  logic                 prd_req_i,
    input  logic                 prd_snoop_done_i,
    input  logic [NXFER-1:0]     xfer_req_i,
    input  logic [NXFER-1:0]     xfer_prio_i,
    input  logic                 pf_req_i,
    input  logic                 done_i,
    output logic [NXFER+3:0]     grant_o
);

    localparam int NSRC = NXFER + 4;

    typedef struct packed {
        logic [NSRC-1:0] grant;
    } arb_state_t;

    arb_state_t              st_d, st_q;
    logic [NSRC-1:0][3:0]    src_lvl;
    logic [NSRC-1:0]         win;
    logic                    bus_free;

    dbus_arb_level_map #(
        .CBF_HI_N (CBF_HI_N),
        .CBF_MED_N(CBF_MED_N),
        .WBF_HI_N (WBF_HI_N),
        .NXFER    (NXFER),
        .NSRC     (NSRC)
    ) u_level_map (
        .cbf_req_i       (cbf_req_i),
        .cbf_hi_cause_i  (cbf_hi_cause_i),
        .cbf_med_cause_i (cbf_med_cause_i),
        .wbf_req_i       (wbf_req_i),
        .wbf_hi_cause_i  (wbf_hi_cause_i),
        .prd_req_i       (prd_req_i),
        .prd_snoop_done_i(prd_snoop_done_i),
        .xfer_req_i      (xfer_req_i),
        .xfer_prio_i     (xfer_prio_i),
        .pf_req_i        (pf_req_i),
        .lvl_o           (src_lvl)
    );

    dbus_arb_pick #(
        .NSRC(NSRC)
    ) u_pick (
        .lvl_i(src_lvl),
        .win_o(win)
    );

    // The bus can change hands only when nobody owns it or the owner is finishing.
    always_comb begin
        st_d     = st_q;
        bus_free = (st_q.grant == '0) || done_i;
        if (bus_free) begin
            st_d.grant = win;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;

endmodule

// File: rtl/dbus_cause_arb_chk.sv
module dbus_cause_arb_chk #(
    parameter int CBF_HI_N  = 5,
    parameter int CBF_MED_N = 3,
    parameter int WBF_HI_N  = 4,
    parameter int NXFER     = 4
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 cbf_req_i,
    input logic [CBF_HI_N-1:0]  cbf_hi_cause_i,
    input logic [CBF_MED_N-1:0] cbf_med_cause_i,
    input logic                 wbf_req_i,
    input logic [WBF_HI_N-1:0]  wbf_hi_cause_i,
    input logic                 prd_req_i,
    input logic                 prd_snoop_done_i,
    input logic [NXFER-1:0]     xfer_req_i,
    input logic [NXFER-1:0]     xfer_prio_i,
    input logic                 pf_req_i,
    input logic                 done_i,
    input logic [NXFER+3:0]     grant_o
);

    logic any_req;
    logic other_than_pf;
    logic free_now;

    assign other_than_pf = cbf_req_i | wbf_req_i | prd_req_i | (|xfer_req_i);
    assign any_req       = other_than_pf | pf_req_i;
    assign free_now      = (grant_o == '0) || done_i;

    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o)); // R3

    AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o != '0 && !done_i) |=> $stable(grant_o)); // R4

    AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_now && !any_req) |=> (grant_o == '0)); // R2

    AST_FREE_REGRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_now && any_req) |=> (grant_o != '0)); // R11

    AST_CBF_URGENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_now && cbf_req_i && (|cbf_hi_cause_i)) |=> grant_o[0]); // R5

    AST_PREFETCH_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_now && other_than_pf) |=> !grant_o[3]); // R10

    AST_PRD_DONE_OVER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_now && prd_req_i && prd_snoop_done_i && !cbf_req_i) |=> grant_o[2]); // R8

endmodule

bind dbus_cause_arb dbus_cause_arb_chk #(
    .CBF_HI_N (CBF_HI_N),
    .CBF_MED_N(CBF_MED_N),
    .WBF_HI_N (WBF_HI_N),
    .NXFER    (NXFER)
) u_chk (.*);

// File: tb/dbus_cause_arb_bench.sv
module dbus_cause_arb_bench;

    localparam int HI_N  = 5;
    localparam int MED_N = 3;
    localparam int WB_N  = 4;
    localparam int NX    = 2;
    localparam int NS    = NX + 4;
    localparam int NONE  = 99;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            cbf_req_i = 1'b0;
    logic [HI_N-1:0] cbf_hi_cause_i = '0;
    logic [MED_N-1:0] cbf_med_cause_i = '0;
    logic            wbf_req_i = 1'b0;
    logic [WB_N-1:0] wbf_hi_cause_i = '0;
    logic            prd_req_i = 1'b0;
    logic            prd_snoop_done_i = 1'b0;
    logic [NX-1:0]   xfer_req_i = '0;
    logic [NX-1:0]   xfer_prio_i = '0;
    logic            pf_req_i = 1'b0;
    logic            done_i = 1'b0;
    logic [NS-1:0]   grant_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk_i = ~clk_i;

    dbus_cause_arb #(
        .CBF_HI_N (HI_N),
        .CBF_MED_N(MED_N),
        .WBF_HI_N (WB_N),
        .NXFER    (NX)
    ) u_dbus_cause_arb (.*);

    task automatic check(input logic [NS-1:0] exp, input string req);
        n_vec++;
        if (grant_o !== exp) begin
            n_fail++;
            $display("FAIL %s grant actual=%b expected=%b", req, grant_o, exp);
        end
    endtask

    task automatic clear_inputs();
        cbf_req_i = 0; cbf_hi_cause_i = '0; cbf_med_cause_i = '0;
        wbf_req_i = 0; wbf_hi_cause_i = '0;
        prd_req_i = 0; prd_snoop_done_i = 0;
        xfer_req_i = '0; xfer_prio_i = '0; pf_req_i = 0;
    endtask

    // Finish current ownership and confirm the bus goes idle.
    task automatic release_bus();
        done_i = 1;
        clear_inputs();
        @(negedge clk_i);
        done_i = 0;
        check('0, "R2");
    endtask

    function automatic string tag_for(input int lvl);
        case (lvl)
            1:       return "R5";
            2, 7:    return "R8";
            3, 6:    return "R9";
            4, 9:    return "R7";
            5, 8:    return "R6";
            10:      return "R10";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int lv [NS];
        repeat (3) @(posedge clk_i);
        check('0, "R1");
        @(negedge clk_i);
        rst_ni = 1;
        @(negedge clk_i);
        check('0, "R1");

        // Sweep: every combination of per-agent level classes.
        for (int p = 0; p < 648; p++) begin
            int c, w, r, f, x0, x1, best, bidx;
            c  = p % 4;
            w  = (p / 4) % 3;
            r  = (p / 12) % 3;
            f  = (p / 36) % 2;
            x0 = (p / 72) % 3;
            x1 = (p / 216) % 3;
            clear_inputs();
            for (int i = 0; i < NS; i++) lv[i] = NONE;
            if (c == 1) begin
                cbf_req_i = 1; cbf_hi_cause_i[p % HI_N] = 1'b1;
                if (p % 2 == 1) cbf_med_cause_i[p % MED_N] = 1'b1; // R12 overlap
                lv[0] = 1;
            end else if (c == 2) begin
                cbf_req_i = 1; cbf_med_cause_i[p % MED_N] = 1'b1; lv[0] = 5;
            end else if (c == 3) begin
                cbf_req_i = 1; lv[0] = 8;
            end
            if (w == 1) begin
                wbf_req_i = 1; wbf_hi_cause_i[p % WB_N] = 1'b1; lv[1] = 4;
            end else if (w == 2) begin
                wbf_req_i = 1; lv[1] = 9;
            end
            if (r == 1) begin
                prd_req_i = 1; prd_snoop_done_i = 1; lv[2] = 2;
            end else if (r == 2) begin
                prd_req_i = 1; lv[2] = 7;
            end
            if (f == 1) begin
                pf_req_i = 1; lv[3] = 10;
            end
            if (x0 != 0) begin
                xfer_req_i[0] = 1; xfer_prio_i[0] = (x0 == 1); lv[4] = (x0 == 1) ? 3 : 6;
            end
            if (x1 != 0) begin
                xfer_req_i[1] = 1; xfer_prio_i[1] = (x1 == 1); lv[5] = (x1 == 1) ? 3 : 6;
            end
            best = NONE; bidx = -1;
            for (int i = 0; i < NS; i++) begin
                if (lv[i] < best) begin best = lv[i]; bidx = i; end
            end
            @(negedge clk_i);
            if (bidx < 0) check('0, "R2");
            else check(NS'(1) << bidx, (best == 1 && c == 1 && p % 2 == 1) ? "R12" : tag_for(best));
            release_bus();
        end

        // Hold: a granted normal transfer is not preempted (R4), then handover (R11).
        xfer_req_i[1] = 1;
        @(negedge clk_i);
        check(6'b100000, "R9");
        cbf_req_i = 1; cbf_hi_cause_i[0] = 1; pf_req_i = 1; prd_req_i = 1; prd_snoop_done_i = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i);
            check(6'b100000, "R4");
        end
        done_i = 1; xfer_req_i = '0;
        @(negedge clk_i);
        done_i = 0;
        check(6'b000001, "R11");
        @(negedge clk_i);
        check(6'b000001, "R4");
        release_bus();

        // Medium plus low cause versus completed PCI read: read wins (R6, R8).
        cbf_req_i = 1; cbf_med_cause_i = 3'b111; prd_req_i = 1; prd_snoop_done_i = 1;
        @(negedge clk_i);
        check(6'b000100, "R6");
        release_bus();

        // All urgent and medium flags together: still level 1 (R12).
        cbf_req_i = 1; cbf_hi_cause_i = '1; cbf_med_cause_i = '1; prd_req_i = 1; prd_snoop_done_i = 1;
        @(negedge clk_i);
        check(6'b000001, "R12");
        release_bus();

        // Done while idle with no request has no effect (R2).
        done_i = 1;
        @(negedge clk_i);
        done_i = 0;
        check('0, "R2");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule